// File: doc/BRIEF.md
# Packed pixel-by-factor rounding multiplier

The block multiplies packed 8-bit pixel components by signed 16-bit factors, four lanes at a time, on a 64-bit data path. A 3-bit opcode picks which bytes of the pixel operand and which 16-bit lanes of the factor operand feed each lane's multiplier. It also picks whether the result is four rounded 16-bit lanes or two unshifted 32-bit lanes.

Every lane rounds the same way. The lane forms the full product. If the product's low byte is greater than 0x7F, the lane adds 0x100. A 16-bit lane result is then bits 23:8 of that sum. A 32-bit lane result is the whole 32-bit sum.

The caller presents `op_a_i` (pixels), `op_b_i` (factors) and the opcode with a one-cycle `in_valid_i` pulse. The result appears in a register one clock later, flagged by `out_valid_o`.

Top module: `pmul8x16`

## Requirements
- R1: Every lane forms the signed product and adds 0x100 (mod 2^32) when the product's bits 7:0 exceed 0x7F. A 16-bit lane takes bits 23:8 of that sum. For example, factor 0x007F times pixel 1 gives 0x0000, factor 0x0080 times pixel 1 gives 0x0001, and factor 0xFF80 times pixel 1 gives 0x0000.
- R2: Opcode 0: result lane r (bits 16r+15:16r) is signed `op_b_i` lane r times unsigned `op_a_i` byte r (bits 8r+7:8r), for r = 0..3.
- R3: Opcode 1: as opcode 0, except that signed `op_b_i` lane 0 is the factor for all four lanes.
- R4: Opcode 2: as opcode 0, except that signed `op_b_i` lane 1 is the factor for all four lanes.
- R5: Opcode 3: result lane r is signed `op_b_i` lane r times the signed upper byte of `op_a_i` lane r (bits 16r+15:16r+8).
- R6: Opcode 4: result lane r is signed `op_b_i` lane r times the unsigned lower byte of `op_a_i` lane r (bits 16r+7:16r).
- R7: Opcodes 5 and 6 use the operand selection of opcodes 3 and 4 for lanes 0 and 1 only. Each of the two rounded 32-bit sums fills result bits 32k+31:32k, for k = 0, 1.
- R8: Opcode 7 yields an all-zero result.
- R9: `out_valid_o` equals `in_valid_i` from the previous clock. `result_o` loads only in a cycle after `in_valid_i` is high, and otherwise holds its value.
- R10: While `rst_ni` is low, `out_valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and opcode are valid this cycle |
| opcode_i | input | 3 | Variant select, codes 0 to 7 |
| op_a_i | input | 64 | Pixel operand |
| op_b_i | input | 64 | Signed 16-bit factor operand |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |

## Verification
The data path holds no state, so a wrong lane selection or rounding decision shows up in `result_o` on the very clock after the operands are accepted, in the affected lane only. A fault in the result register shows up in the first idle cycle, when the output drifts although no operands were accepted. A fault in the valid register shows up as an `out_valid_o` that does not follow `in_valid_i` by exactly one clock. Directed operands whose products end in 0x7F, 0x80 and 0xFF80 separate a correct rounding threshold from one that is off by one.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned FAC_W  = 16;
  localparam int unsigned PROD_W = 2 * FAC_W;
  localparam int unsigned DATA_W = LANES * FAC_W;
  localparam int unsigned RAW_W  = FAC_W + PIX_W + 1;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned WIDE_LANES = DATA_W / PROD_W;

  typedef enum logic [OP_W-1:0] {
    OP_BASIC  = 3'd0,
    OP_BCAST0 = 3'd1,
    OP_BCAST1 = 3'd2,
    OP_HI_S   = 3'd3,
    OP_LO_U   = 3'd4,
    OP_DHI_S  = 3'd5,
    OP_DLO_U  = 3'd6,
    OP_NONE   = 3'd7
  } pmul_op_e;
endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
  import pmul_pkg::*;
(
  input  pmul_op_e                      op_i,
  input  logic [DATA_W-1:0]             op_a_i,
  input  logic [DATA_W-1:0]             op_b_i,
  output logic [LANES-1:0][FAC_W-1:0]   fac_o,
  output logic [LANES-1:0][PIX_W:0]     pix_o
);
  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic [PIX_W-1:0] byte_r, hi_r, lo_r;
    assign byte_r = op_a_i[r*PIX_W +: PIX_W];
    assign hi_r   = op_a_i[r*FAC_W + PIX_W +: PIX_W];
    assign lo_r   = op_a_i[r*FAC_W +: PIX_W];

    always_comb begin
      unique case (op_i)
        OP_BCAST0: fac_o[r] = op_b_i[0 +: FAC_W];
        OP_BCAST1: fac_o[r] = op_b_i[FAC_W +: FAC_W];
        default:   fac_o[r] = op_b_i[r*FAC_W +: FAC_W];
      endcase
      unique case (op_i)
        OP_HI_S, OP_DHI_S: pix_o[r] = {hi_r[PIX_W-1], hi_r};
        OP_LO_U, OP_DLO_U: pix_o[r] = {1'b0, lo_r};
        default:           pix_o[r] = {1'b0, byte_r};
      endcase
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
(
  input  logic [FAC_W-1:0]  fac_i,
  input  logic [PIX_W:0]    pix_i,
  output logic [PROD_W-1:0] prod_o
);
  localparam logic [PROD_W-1:0] RND_INC = PROD_W'(1) << PIX_W;

  logic signed [RAW_W-1:0] raw;
  logic [PROD_W-1:0]       ext;

  assign raw = RAW_W'($signed(fac_i)) * RAW_W'($signed(pix_i));
  assign ext = {{(PROD_W-RAW_W){raw[RAW_W-1]}}, raw};
  // low byte above 0x7F <=> its top bit set
  assign prod_o = ext + (raw[PIX_W-1] ? RND_INC : '0);
endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
  import pmul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o
);
  pmul_op_e                    op;
  logic [LANES-1:0][FAC_W-1:0] fac;
  logic [LANES-1:0][PIX_W:0]   pix;
  logic [PROD_W-1:0]           prod [LANES];
  logic [DATA_W-1:0]           res_d;

  assign op = pmul_op_e'(opcode_i);

  pmul_operand_sel u_sel (
    .op_i   (op),
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .fac_o  (fac),
    .pix_o  (pix)
  );

  for (genvar r = 0; r < LANES; r++) begin : g_mul
    pmul_lane u_lane (
      .fac_i  (fac[r]),
      .pix_i  (pix[r]),
      .prod_o (prod[r])
    );
  end

  always_comb begin
    res_d = '0;
    unique case (op)
      OP_BASIC, OP_BCAST0, OP_BCAST1, OP_HI_S, OP_LO_U: begin
        for (int r = 0; r < LANES; r++) res_d[r*FAC_W +: FAC_W] = prod[r][PIX_W +: FAC_W];
      end
      OP_DHI_S, OP_DLO_U: begin
        for (int k = 0; k < WIDE_LANES; k++) res_d[k*PROD_W +: PROD_W] = prod[k];
      end
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/pmul8x16_chk.sv
module pmul8x16_chk
  import pmul_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [OP_W-1:0]   opcode_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] result_o
);
  p_valid_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_valid_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(result_o));
  p_zero_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == 3'd7) |=> (result_o == '0));
  p_zero_factor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == 3'd0 && op_b_i == '0) |=> (result_o == '0));
  p_bcast_equal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && opcode_i == 3'd1 && op_a_i == 64'h0101_0101_0101_0101) |=>
      (result_o[15:0] == result_o[31:16] && result_o[31:16] == result_o[47:32]
       && result_o[47:32] == result_o[63:48]));
  p_wide_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (opcode_i == 3'd5 || opcode_i == 3'd6) && op_a_i == '0) |=>
      (result_o == '0));

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_r10: assert (!out_valid_o && result_o == '0);
  end
endmodule

bind pmul8x16 pmul8x16_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .opcode_i    (opcode_i),
  .op_a_i      (op_a_i),
  .op_b_i      (op_b_i),
  .out_valid_o (out_valid_o),
  .result_o    (result_o)
);

// File: tb/tb_pmul8x16.sv
`timescale 1ns/1ps
module tb_pmul8x16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  opcode_i = '0;
  logic [63:0] op_a_i = '0;
  logic [63:0] op_b_i = '0;
  logic        out_valid_o;
  logic [63:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  logic [2:0]  exp_op = '0;
  bit          cmp_en = 0;

  always #4 clk_i = ~clk_i;

  pmul8x16 dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .out_valid_o(out_valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] ref_model(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    for (int l = 0; l < 4; l++) begin
      int fi = (op == 3'd1) ? 0 : (op == 3'd2) ? 1 : l;
      longint f = longint'($signed(b[16*fi +: 16]));
      longint p;
      longint prod;
      logic [31:0] t;
      if (op == 3'd3 || op == 3'd5) p = longint'($signed(a[16*l+8 +: 8]));
      else if (op == 3'd4 || op == 3'd6) p = longint'(a[16*l +: 8]);
      else p = longint'(a[8*l +: 8]);
      prod = f * p;
      t = prod[31:0];
      if (t[7:0] > 8'h7f) t = t + 32'h100;
      if (op <= 3'd4) r[16*l +: 16] = t[23:8];
      else if (op <= 3'd6 && l < 2) r[32*l +: 32] = t;
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural model, advanced on every clock
  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_v <= in_valid_i;
      if (in_valid_i) begin
        exp_r  <= ref_model(opcode_i, op_a_i, op_b_i);
        exp_op <= opcode_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni) begin
      check(out_valid_o == exp_v, "R9 valid", 64'(out_valid_o), 64'(exp_v));
      check(result_o == exp_r, exp_v ? tag_of(exp_op) : "R9 hold", result_o, exp_r);
    end
  end

  task automatic issue(bit v, logic [2:0] op, logic [63:0] a, logic [63:0] b);
    in_valid_i = v; opcode_i = op; op_a_i = a; op_b_i = b;
    @(negedge clk_i);
  endtask

  task automatic directed(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                          logic [63:0] exp, string tag);
    issue(1'b1, op, a, b);
    check(result_o == exp, tag, result_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 1'b0 && result_o == '0, "R10 reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_en = 1;
    // R1 rounding threshold
    directed(3'd0, 64'h1, 64'h007F, 64'h0, "R1 low byte 7F");
    directed(3'd0, 64'h1, 64'h0080, 64'h1, "R1 low byte 80");
    directed(3'd0, 64'h1, 64'hFF80, 64'h0, "R1 negative 80");
    directed(3'd0, 64'h2, 64'h0040, 64'h1, "R1 product 80");
    directed(3'd0, 64'h1, 64'h017F, 64'h1, "R1 product 17F");
    // R3/R4 broadcast, R7 wide, R8 zero
    directed(3'd1, 64'h0403_0201_0403_0201, 64'h0000_0000_0200_0100,
             64'h0004_0003_0002_0001, "R3 lane0 factor");
    directed(3'd2, 64'h0403_0201_0403_0201, 64'h0000_0000_0200_0100,
             64'h0008_0006_0004_0002, "R4 lane1 factor");
    directed(3'd5, 64'h0000_0000_0100_FF00, 64'h0000_0000_0100_0100,
             64'h0000_0100_FFFF_FF00, "R7 signed upper wide");
    directed(3'd6, 64'h0000_0000_00FF_0080, 64'h0000_0000_0001_0001,
             64'h0000_01FF_0000_0180, "R7 unsigned lower wide");
    directed(3'd7, '1, '1, 64'h0, "R8 code 7");
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom_range(0, 3) != 0);
      logic [2:0] op = 3'($urandom_range(0, 7));
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (i % 5 == 0) b[15:0] = {8'($urandom), (i % 2 == 0) ? 8'h7F : 8'h80};
      issue(v, op, a, b);
    end
    issue(1'b0, 3'd0, '0, '0);
    issue(1'b0, 3'd3, '1, '1);
    rst_ni = 1'b0;
    #1;
    check(out_valid_o == 1'b0 && result_o == '0, "R10 async clear", result_o, '0);
    cmp_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule